// File: doc/BRIEF.md
# I2C Slave Address Recognizer Receiver

This block listens on an I2C bus as a receive-only slave. It oversamples SCL and SDA with the system clock. It finds START and STOP conditions and shifts in the first byte after each START. That byte is then compared with two things: a programmed own address and the reserved all-zero general-call address. The two outcomes are reported on separate flags, and a one-cycle interrupt pulse marks either one.

Once the block is addressed, it takes in data bytes one after another, most significant bit first. Each completed byte is presented with a one-cycle strobe. This continues until a STOP arrives. The acknowledge bit is normally driven low through an open-drain style enable. When the no-acknowledge input is set, the block never drives SDA. A sampling clock of at least about twenty times the SCL rate is assumed, which covers fast mode at 400 kHz.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset, `gc_hit`, `own_hit`, `irq`, `rx_valid` and `sda_oe` are all 0.
- R2: A first byte after START equal to 8'h00 sets `gc_hit` to 1 and `own_hit` to 0, and raises `irq` for exactly one clock.
- R3: A first byte after START equal to `own_addr` sets `own_hit` and raises one `irq` pulse. Bits 7:1 of `own_addr` hold the 7-bit address and bit 0 is the direction bit, which is programmed 0 for a write. The byte must match all 8 bits, so a read request to the same address does not match.
- R4: Any other first byte leaves both flags at 0. It raises no `irq`, gets no acknowledge, and the data bytes that follow produce no `rx_valid`.
- R5: When the block is addressed and `ack_off` is 0, `sda_oe` pulls SDA low for the whole ninth SCL clock of the address byte and of every data byte.
- R6: When `ack_off` is 1, `sda_oe` stays 0 at all times.
- R7: In an addressed transfer, each data byte is sampled on SCL rising edges, MSB first. It is presented on `rx_data` together with a one-clock `rx_valid` pulse.
- R8: A STOP (SDA rising while SCL is high) clears both flags. Bytes clocked on the bus after that without a new START are ignored.
- R9: A repeated START restarts address comparison, and the flags take the result of the new address byte.
- R10: `irq` and `rx_valid` never stay high for two clocks in a row, and `gc_hit` and `own_hit` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| own_addr | input | 8 | Own address in bits 7:1, direction bit in bit 0 |
| ack_off | input | 1 | 1 disables driving the acknowledge bit |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a new data byte |
| gc_hit | output | 1 | General-call address received |
| own_hit | output | 1 | Own address received |
| irq | output | 1 | One-cycle pulse when either flag is set |

## Verification
A wrong bit count or a slipped shift register shows up within one byte time. It appears as a misplaced acknowledge on the wire during the ninth clock, or as a data byte on `rx_data` that does not match what was sent. A wrong comparison result, or a mode state that is not cleared, shows at the end of the address byte through the flags and the `irq` count. A failure to return to idle on STOP shows in the next bytes clocked without a START, as a stray acknowledge or a stray `rx_valid`. The bench also checks that the flags read 0 right after each STOP.

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] own_addr,
  input  logic       ack_off,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       gc_hit,
  output logic       own_hit,
  output logic       irq
);
  localparam logic [1:0] M_IDLE = 2'd0, M_ADDR = 2'd1, M_DATA = 2'd2, M_SKIP = 2'd3;

  logic [1:0] scl_sr, sda_sr, mode;
  logic       scl_d, sda_d;
  logic [7:0] shreg;
  logic [3:0] cnt;

  wire scl      = scl_sr[1];
  wire sda      = sda_sr[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire [7:0] nxt = {shreg[6:0], sda};
  wire gc_m  = (nxt == 8'h00);
  wire own_m = !gc_m && (nxt == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= 2'b11;
      sda_sr <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[0], scl_i};
      sda_sr <= {sda_sr[0], sda_i};
      scl_d  <= scl;
      sda_d  <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      gc_hit   <= 1'b0;
      own_hit  <= 1'b0;
      irq      <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      irq      <= 1'b0;
      rx_valid <= 1'b0;
      if (stop_c) begin
        mode    <= M_IDLE;
        cnt     <= '0;
        gc_hit  <= 1'b0;
        own_hit <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (start_c) begin
        mode   <= M_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise && mode != M_IDLE) begin
          if (cnt == 4'd8) begin
            cnt <= '0;
          end else begin
            shreg <= nxt;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              if (mode == M_ADDR) begin
                gc_hit  <= gc_m;
                own_hit <= own_m;
                irq     <= gc_m | own_m;
                mode    <= (gc_m | own_m) ? M_DATA : M_SKIP;
              end else if (mode == M_DATA) begin
                rx_data  <= nxt;
                rx_valid <= 1'b1;
              end
            end
          end
        end
        if (scl_fall)
          sda_oe <= (cnt == 4'd8) && (mode == M_DATA) && !ack_off;
      end
    end
  end
endmodule

module i2c_addr_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic ack_off,
  input logic rx_valid,
  input logic gc_hit,
  input logic own_hit,
  input logic irq
);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gc_hit && own_hit));
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_irq_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gc_hit || own_hit));
  assert_data_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (gc_hit || own_hit));
  assert_ack_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (gc_hit || own_hit));
  assert_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_off && $past(ack_off)) |-> !sda_oe);
endmodule

bind i2c_addr_rx i2c_addr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ack_off(ack_off),
  .rx_valid(rx_valid), .gc_hit(gc_hit), .own_hit(own_hit), .irq(irq)
);

// File: tb/i2c_addr_rx_test.sv
module i2c_addr_rx_test;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [7:0] own_addr = 8'h00;
  logic ack_off = 1'b0;
  logic sda_oe, rx_valid, gc_hit, own_hit, irq;
  logic [7:0] rx_data;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0, irq_cnt = 0, rx_n = 0, oe_cnt = 0;
  logic [7:0] rx_last;

  always #2.5 clk = ~clk;

  i2c_addr_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .own_addr(own_addr), .ack_off(ack_off), .rx_data(rx_data), .rx_valid(rx_valid),
    .gc_hit(gc_hit), .own_hit(own_hit), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rx_valid) begin rx_n++; rx_last = rx_data; end
    if (sda_oe) oe_cnt++;
  end

  function automatic bit exp_gc(input logic [7:0] a);
    return a == 8'h00;
  endfunction
  function automatic bit exp_own(input logic [7:0] a, input logic [7:0] o);
    return !exp_gc(a) && a == o;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q); sda_m = 1'b0; wc(Q); scl = 1'b0; wc(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wc(Q); scl = 1'b1; wc(Q); sda_m = 1'b1; wc(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(Q); scl = 1'b1; wc(2 * Q); scl = 1'b0; wc(Q);
    end
    sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q);
    acked = !sda_bus;
    wc(Q); scl = 1'b0; wc(Q);
  endtask

  task automatic xact(input logic [7:0] a, input int nd, input bit rs, input logic [7:0] a2);
    bit ack, eg, eo, hit;
    int i0, r0;
    logic [7:0] d;
    eg = exp_gc(a); eo = exp_own(a, own_addr); hit = eg | eo;
    i0 = irq_cnt;
    do_start();
    send_byte(a, ack);
    check("R5 R6 R4 address ack", ack, hit && !ack_off);
    check("R2 gc flag", gc_hit, eg);
    check("R3 own flag", own_hit, eo);
    check("R10 irq pulses", irq_cnt - i0, hit);
    for (int k = 0; k < nd; k++) begin
      d = 8'($urandom);
      r0 = rx_n;
      send_byte(d, ack);
      check("R7 R4 byte strobes", rx_n - r0, hit);
      if (hit) check("R7 data value", rx_last, d);
      check("R5 R6 data ack", ack, hit && !ack_off);
    end
    if (rs) begin
      eg = exp_gc(a2); eo = exp_own(a2, own_addr);
      do_start();
      send_byte(a2, ack);
      check("R9 gc after restart", gc_hit, eg);
      check("R9 own after restart", own_hit, eo);
      check("R9 ack after restart", ack, (eg | eo) && !ack_off);
    end
    do_stop();
    check("R8 gc clear", gc_hit, 0);
    check("R8 own clear", own_hit, 0);
  endtask

  initial begin
    bit ack;
    int r0, o0;
    logic [7:0] a;
    void'($urandom(32'd4711));
    wc(4);
    check("R1 gc", gc_hit, 0); check("R1 own", own_hit, 0);
    check("R1 irq", irq, 0); check("R1 rx_valid", rx_valid, 0); check("R1 sda_oe", sda_oe, 0);
    rst_n = 1'b1; wc(4);
    own_addr = 8'h5A & 8'hFE;
    xact(8'h00, 2, 0, 8'h00);
    xact(own_addr, 3, 0, 8'h00);
    xact(own_addr | 8'h01, 2, 0, 8'h00);
    xact(8'h33, 2, 0, 8'h00);
    xact(8'h33, 1, 1, own_addr);
    xact(own_addr, 1, 1, 8'h00);
    ack_off = 1'b1; wc(2);
    o0 = oe_cnt;
    xact(own_addr, 2, 0, 8'h00);
    xact(8'h00, 1, 0, 8'h00);
    check("R6 sda never driven", oe_cnt - o0, 0);
    ack_off = 1'b0;
    r0 = rx_n;
    send_byte(8'h96, ack);
    send_byte(own_addr, ack);
    check("R8 no ack without start", ack, 0);
    check("R8 no data without start", rx_n - r0, 0);
    for (int t = 0; t < 30; t++) begin
      own_addr = {7'($urandom_range(1, 127)), 1'b0};
      ack_off = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 5))
        0: a = 8'h00;
        1, 2: a = own_addr;
        default: a = 8'($urandom);
      endcase
      xact(a, $urandom_range(0, 3), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 1) == 1) ? own_addr : 8'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule